// File: doc/BRIEF.md
# Serial EEPROM Configuration Auto-Loader with Verify

This engine brings up a device's memory and registers from a configuration image held in an external serial EEPROM. When a start pulse arrives while it is idle, it asks an SPI master for the image bytes one at a time. It writes each byte into local memory at the same address. It then reads the whole image again and compares every byte with what local memory now holds. If every byte matches, it reads one more EEPROM byte that follows the image, the stored checksum, and checks the arithmetic sum.

The two checks report through separate pending bits that cannot be masked: one bit for a compare mismatch and one for a bad checksum. When the compare fails, the failing address is kept in two byte-wide registers. Either error raises the master interrupt and a request to put the device in a safe state. Each run ends with a one-cycle done pulse. The byte-read interface is a request/acknowledge pair: the engine holds a request and an address, and the SPI master answers with an acknowledge and the byte. Local memory offers a write port and a read port with one cycle of read latency.

Top module: `cfg_autoload`

## Requirements
- R1: After reset the engine is idle. `busy`, `ee_req`, `done`, `irq`, `safe_req`, both pending bits and both failing-address bytes are all 0.
- R2: A `start` pulse while idle begins a copy pass. For k = 0 .. IMG_LEN-1 in ascending order, the byte acknowledged for EEPROM address k is written exactly once to local address k, unchanged.
- R3: `ee_req` stays high with `ee_addr` held until the cycle in which `ee_ack` is high. Each acknowledge delivers exactly one byte on `ee_data`.
- R4: After the copy, a verify pass re-requests EEPROM addresses 0 .. IMG_LEN-1 in order. Each returned byte is compared with local memory at the same address, read through `mem_raddr`/`mem_rdata` with one cycle of latency.
- R5: On the first verify mismatch, `pend_cmp_err` is set and the run ends at once. No further addresses are read, the checksum byte is not read, and `pend_chk_err` stays 0. The run therefore makes IMG_LEN + k + 1 reads for a mismatch at address k.
- R6: On a verify mismatch at address k, `fail_addr_lo` captures bits 7:0 of k and `fail_addr_hi` captures bits 15:8 of k.
- R7: If every byte matches, the engine reads EEPROM address IMG_LEN, for 2*IMG_LEN + 1 reads in all. The 8-bit sum of image bytes 0 .. IMG_LEN-1 plus that stored byte must be 0 modulo 256; otherwise `pend_chk_err` is set.
- R8: `irq` and `safe_req` are high whenever either pending bit is set. No input can mask them.
- R9: `done` is high for exactly one cycle at the end of every run, and the pending bits and failing address are already valid in that cycle. `busy` is low in the following cycle.
- R10: A `start` pulse while busy is ignored. The run continues without restarting and still writes exactly IMG_LEN bytes.
- R11: Starting a new run clears both pending bits and both failing-address bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load run (used only when idle) |
| ee_req | output | 1 | Byte read request to the SPI master |
| ee_addr | output | AW | EEPROM byte address of the request |
| ee_ack | input | 1 | Byte delivered, one-cycle pulse |
| ee_data | input | 8 | Byte read from the EEPROM |
| mem_we | output | 1 | Local memory write enable |
| mem_waddr | output | AW | Local memory write address |
| mem_wdata | output | 8 | Local memory write data |
| mem_raddr | output | AW | Local memory read address |
| mem_rdata | input | 8 | Local memory read data, one cycle after address |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pend_cmp_err | output | 1 | Compare-mismatch pending bit |
| pend_chk_err | output | 1 | Checksum pending bit |
| fail_addr_lo | output | 8 | Failing address bits 7:0 |
| fail_addr_hi | output | 8 | Failing address bits 15:8 |
| irq | output | 1 | Master interrupt |
| safe_req | output | 1 | Request to enter the safe state |

## Verification
The assertions assume that `ee_ack` rises only while `ee_req` is high, and no sooner than one cycle after `ee_addr` last changed. Local memory is assumed to return read data one cycle after the address. Together these guarantee that `mem_rdata` is valid whenever a verify byte is acknowledged. The bench's SPI responder waits at least one idle cycle plus one to three more before each acknowledge. Its memory model registers read data on each clock edge. Faults are introduced only by corrupting a stored byte or the checksum byte, never by breaking the handshake.

// File: rtl/cfg_autoload_pkg.sv
package cfg_autoload_pkg;

  typedef enum logic [2:0] {
    AL_IDLE,
    AL_COPY,
    AL_VERIFY,
    AL_SUMBYTE,
    AL_END
  } al_state_e;

  // running 8-bit checksum, wraps modulo 256
  function automatic logic [7:0] sum8(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  // byte compare used by the verify pass
  function automatic logic bytes_differ(input logic [7:0] a, input logic [7:0] b);
    return (a ^ b) != 8'h00;
  endfunction

endpackage

// File: rtl/autoload_seq.sv
module autoload_seq
  import cfg_autoload_pkg::*;
#(
  parameter int IMG_LEN = 64,
  parameter int AW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ee_ack,
  input  logic          mismatch_ev,
  output logic          start_acc,
  output logic          copy_ack,
  output logic          verify_ack,
  output logic          sumbyte_ack,
  output logic [AW-1:0] idx,
  output logic          ee_req,
  output logic          busy,
  output logic          done
);

  localparam logic [AW-1:0] LAST_IDX = AW'(IMG_LEN - 1);
  localparam logic [AW-1:0] SUM_IDX  = AW'(IMG_LEN);

  al_state_e state;
  logic      at_last;

  assign at_last     = (idx == LAST_IDX);
  assign start_acc   = (state == AL_IDLE) && start;
  assign copy_ack    = (state == AL_COPY) && ee_ack;
  assign verify_ack  = (state == AL_VERIFY) && ee_ack;
  assign sumbyte_ack = (state == AL_SUMBYTE) && ee_ack;
  assign ee_req      = (state == AL_COPY) || (state == AL_VERIFY) || (state == AL_SUMBYTE);
  assign busy        = (state != AL_IDLE);
  assign done        = (state == AL_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= AL_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        AL_IDLE: begin
          if (start) begin
            state <= AL_COPY;
            idx   <= '0;
          end
        end
        AL_COPY: begin
          if (ee_ack) begin
            if (at_last) begin
              state <= AL_VERIFY;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        AL_VERIFY: begin
          if (ee_ack) begin
            if (mismatch_ev) begin
              state <= AL_END;
            end else if (at_last) begin
              state <= AL_SUMBYTE;
              idx   <= SUM_IDX;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        AL_SUMBYTE: begin
          if (ee_ack) state <= AL_END;
        end
        AL_END: state <= AL_IDLE;
        default: state <= AL_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_ack) |=> (ee_req && $stable(idx)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req |-> (idx <= SUM_IDX));

endmodule

// File: rtl/autoload_sum.sv
module autoload_sum
  import cfg_autoload_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_acc,
  input  logic       copy_ack,
  input  logic       sumbyte_ack,
  input  logic [7:0] ee_data,
  output logic       chk_fail_ev
);

  logic [7:0] acc;
  logic [7:0] final_sum;

  assign final_sum   = sum8(acc, ee_data);
  assign chk_fail_ev = sumbyte_ack && (final_sum != 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= 8'h00;
    end else if (start_acc) begin
      acc <= 8'h00;
    end else if (copy_ack) begin
      acc <= sum8(acc, ee_data);
    end
  end

  // R7
  sum_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fail_ev |-> !copy_ack);

endmodule

// File: rtl/autoload_errcap.sv
module autoload_errcap #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_acc,
  input  logic          cmp_fail_ev,
  input  logic          chk_fail_ev,
  input  logic [AW-1:0] fail_idx,
  output logic          pend_cmp,
  output logic          pend_chk,
  output logic [7:0]    fail_lo,
  output logic [7:0]    fail_hi
);

  logic [15:0] idx16;
  assign idx16 = 16'(fail_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_cmp <= 1'b0;
      pend_chk <= 1'b0;
      fail_lo  <= 8'h00;
      fail_hi  <= 8'h00;
    end else if (start_acc) begin
      pend_cmp <= 1'b0;
      pend_chk <= 1'b0;
      fail_lo  <= 8'h00;
      fail_hi  <= 8'h00;
    end else begin
      if (cmp_fail_ev) begin
        pend_cmp <= 1'b1;
        fail_lo  <= idx16[7:0];
        fail_hi  <= idx16[15:8];
      end
      if (chk_fail_ev) pend_chk <= 1'b1;
    end
  end

  // R5
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fail_ev |=> (pend_cmp && !pend_chk));

  // R6
  fail_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fail_ev |=> ({fail_hi, fail_lo} == $past(idx16)));

  // R7
  chk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fail_ev |=> pend_chk);

  // R5
  single_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_cmp && pend_chk));

  // R11
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (!pend_cmp && !pend_chk && fail_lo == 8'h00 && fail_hi == 8'h00));

endmodule

// File: rtl/cfg_autoload.sv
module cfg_autoload
  import cfg_autoload_pkg::*;
#(
  parameter int IMG_LEN = 64,
  parameter int AW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          ee_req,
  output logic [AW-1:0] ee_addr,
  input  logic          ee_ack,
  input  logic [7:0]    ee_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] mem_raddr,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          pend_cmp_err,
  output logic          pend_chk_err,
  output logic [7:0]    fail_addr_lo,
  output logic [7:0]    fail_addr_hi,
  output logic          irq,
  output logic          safe_req
);

  // internal events, named for the assertions
  logic          start_acc;
  logic          copy_ack;
  logic          verify_ack;
  logic          sumbyte_ack;
  logic          cmp_fail_ev;
  logic          chk_fail_ev;
  logic [AW-1:0] idx;

  assign cmp_fail_ev = verify_ack && bytes_differ(ee_data, mem_rdata);

  autoload_seq #(.IMG_LEN(IMG_LEN), .AW(AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ee_ack      (ee_ack),
    .mismatch_ev (cmp_fail_ev),
    .start_acc   (start_acc),
    .copy_ack    (copy_ack),
    .verify_ack  (verify_ack),
    .sumbyte_ack (sumbyte_ack),
    .idx         (idx),
    .ee_req      (ee_req),
    .busy        (busy),
    .done        (done)
  );

  autoload_sum u_sum (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_acc   (start_acc),
    .copy_ack    (copy_ack),
    .sumbyte_ack (sumbyte_ack),
    .ee_data     (ee_data),
    .chk_fail_ev (chk_fail_ev)
  );

  autoload_errcap #(.AW(AW)) u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_acc   (start_acc),
    .cmp_fail_ev (cmp_fail_ev),
    .chk_fail_ev (chk_fail_ev),
    .fail_idx    (idx),
    .pend_cmp    (pend_cmp_err),
    .pend_chk    (pend_chk_err),
    .fail_lo     (fail_addr_lo),
    .fail_hi     (fail_addr_hi)
  );

  assign ee_addr   = idx;
  assign mem_raddr = idx;
  assign mem_we    = copy_ack;
  assign mem_waddr = idx;
  assign mem_wdata = ee_data;
  assign irq       = pend_cmp_err | pend_chk_err;
  assign safe_req  = pend_cmp_err | pend_chk_err;

  // R2
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_waddr < AW'(IMG_LEN)));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fail_ev || chk_fail_ev) |=> (irq && safe_req));

  // R4
  verify_after_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verify_ack |-> !mem_we);

endmodule

// File: tb/cfg_autoload_bench.sv
module cfg_autoload_bench;

  localparam int N  = 300;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          ee_req;
  logic [AW-1:0] ee_addr;
  logic          ee_ack = 1'b0;
  logic [7:0]    ee_data = 8'h00;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic [AW-1:0] mem_raddr;
  logic [7:0]    mem_rdata = 8'h00;
  logic          busy, done, pend_cmp_err, pend_chk_err, irq, safe_req;
  logic [7:0]    fail_addr_lo, fail_addr_hi;

  always #10 clk = ~clk;

  cfg_autoload #(.IMG_LEN(N), .AW(AW)) u_cfg_autoload (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ee_req(ee_req), .ee_addr(ee_addr), .ee_ack(ee_ack), .ee_data(ee_data),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .pend_cmp_err(pend_cmp_err), .pend_chk_err(pend_chk_err),
    .fail_addr_lo(fail_addr_lo), .fail_addr_hi(fail_addr_hi), .irq(irq), .safe_req(safe_req)
  );

  logic [7:0] eeprom [0:N];
  logic [7:0] lmem   [0:N];
  bit         fault_en = 1'b0;
  int         fault_addr = 0;
  int         rd_cnt = 0, wr_cnt = 0, wr_bad = 0;
  int         n_chk = 0, n_fail = 0, runs_started = 0, runs_seen = 0;

  typedef struct {
    bit   cmp;
    bit   chk;
    int   fail_at;
    int   reads;
  } exp_t;
  exp_t sb_q[$];

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // SPI responder: idle cycle plus 1..3 cycles latency per byte
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (ee_req) begin
        repeat (1 + (lat % 3)) @(negedge clk);
        lat++;
        ee_data = eeprom[int'(ee_addr)];
        ee_ack  = 1'b1;
        @(negedge clk);
        ee_ack  = 1'b0;
      end
    end
  end

  // local memory model with one-cycle read latency and an optional corrupt cell
  initial begin
    forever begin
      @(posedge clk);
      if (ee_ack) rd_cnt <= rd_cnt + 1;
      if (mem_we) begin
        wr_cnt <= wr_cnt + 1;
        if (mem_wdata != eeprom[int'(mem_waddr)]) wr_bad <= wr_bad + 1;
        lmem[int'(mem_waddr)] <= (fault_en && int'(mem_waddr) == fault_addr)
                                 ? (mem_wdata ^ 8'h80) : mem_wdata;
      end
      mem_rdata <= lmem[int'(mem_raddr)];
    end
  end

  // monitor: pops the expectation on each done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        exp_t e;
        e = sb_q.pop_front();
        check("R5 compare pending bit", int'(pend_cmp_err), int'(e.cmp));
        check("R7 checksum pending bit", int'(pend_chk_err), int'(e.chk));
        check("R6 fail_addr_lo", int'(fail_addr_lo), e.cmp ? (e.fail_at & 8'hff) : 0);
        check("R6 fail_addr_hi", int'(fail_addr_hi), e.cmp ? ((e.fail_at >> 8) & 8'hff) : 0);
        check("R8 irq", int'(irq), int'(e.cmp || e.chk));
        check("R8 safe_req", int'(safe_req), int'(e.cmp || e.chk));
        check("R5 R7 read count", rd_cnt, e.reads);
        check("R2 R10 write count", wr_cnt, N);
        check("R2 write data", wr_bad, 0);
        @(negedge clk);
        check("R9 done one cycle", int'(done), 0);
        check("R9 busy low after done", int'(busy), 0);
        runs_seen++;
      end
    end
  end

  // driver: build image, push expectation, start run
  task automatic do_run(input bit f_en, input int f_at, input bit bad_sum, input bit poke);
    exp_t e;
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < N; i++) begin
      eeprom[i] = 8'((i * 13 + 5) ^ (i >> 3));
      s = s + eeprom[i];
    end
    eeprom[N] = (8'h00 - s) + (bad_sum ? 8'h01 : 8'h00);
    fault_en   = f_en;
    fault_addr = f_at;
    e.cmp     = f_en;
    e.chk     = !f_en && bad_sum;
    e.fail_at = f_at;
    e.reads   = f_en ? (N + f_at + 1) : (2 * N + 1);
    sb_q.push_back(e);
    rd_cnt = 0; wr_cnt = 0; wr_bad = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    runs_started++;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1;  // R10: start while busy
      @(negedge clk) start = 1'b0;
    end
    while (runs_seen < runs_started) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int diff;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 ee_req", int'(ee_req), 0);
    check("R1 pending", int'({pend_cmp_err, pend_chk_err}), 0);
    check("R1 fail addr", int'({fail_addr_hi, fail_addr_lo}), 0);
    check("R1 irq safe done", int'({irq, safe_req, done}), 0);

    // R2 R4 R7 clean image
    do_run(1'b0, 0, 1'b0, 1'b0);
    diff = 0;
    for (int i = 0; i < N; i++) if (lmem[i] !== eeprom[i]) diff++;
    check("R2 local image matches", diff, 0);

    // R5 R6 mismatch above 255 exercises high byte
    do_run(1'b1, 'h11A, 1'b0, 1'b0);
    // R7 R11 bad checksum clears previous fail address
    do_run(1'b0, 0, 1'b1, 1'b0);
    // R5 abort at address 0, checksum also bad but not evaluated
    do_run(1'b1, 0, 1'b1, 1'b0);
    // R10 R11 start while busy, clean image
    do_run(1'b0, 0, 1'b0, 1'b1);
    check("R11 cleared after good run", int'({pend_cmp_err, pend_chk_err, irq}), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule